// File: doc/BRIEF.md
# Dual-Port Synchronous Byte-Write RAM

A true dual-port static memory with one independent clock per port. Each port captures address, write data and control on the rising edge of its own clock, and any word can be reached from either port in the same cycle. A word is split into two 9-bit byte lanes, and a port writes or reads only the lanes whose active-low lane selects are asserted. A port is selected only while its active-low select is low and its active-high select is high. The three-state data bus is modelled as separate data-in, data-out and per-lane drive-enable signals. A lane that is not driven reads as zero.

Each port has a static latency input. In flow-through mode, read data appears after the edge that captured the read. In pipelined mode it appears one edge later. In pipelined mode the port selects pass through two registers, so a port keeps driving for one more cycle after it is deselected. The lane selects always pass through one register. An active-low output enable gates the drivers without any clock.

When both ports write the same word in the same cycle, the stored value is undefined. When one port reads a word that the other port writes in the same cycle, it may return either the old or the new value. The array depth is 2**ADDR_W words. The full-size configuration uses ADDR_W = 14, which gives 16384 words. The default is smaller so that the model stays light.

Top module: `dp_bw_ram`

## Requirements
- R1: The array holds 2**ADDR_W words of 18 bits. A word written through one port reads back unchanged through the other port.
- R2: lane_n bit 0 selects data bits 8:0 and lane_n bit 1 selects bits 17:9, both active low. A write changes only the selected lanes and leaves the other lane of the word as it was.
- R3: A port is selected only when cs_n is 0 and cs is 1. When a port is not selected, it writes nothing and drives no lane in the output window of that capture.
- R4: With both lane selects high (lane_n = 2'b11), a selected port neither writes nor drives.
- R5: A read drives only the selected lanes, with dout_en bit l high for lane l. A lane whose dout_en bit is low reads as zero on dout.
- R6: With pipe = 0, a read captured at edge k drives after edge k. With pipe = 1, it drives after edge k+1, and nothing from it is driven between edge k and edge k+1.
- R7: With pipe = 1, the port select passes through two registers and the lane selects through one. The lanes driven after edge k+1 therefore follow the lane selects captured at edge k+1, and a port deselected at edge k+1 still drives the read captured at edge k.
- R8: With out_en_n high, dout_en and dout are zero at once, with no clock edge needed.
- R9: While rst_ni is low, no port drives, and both dout_en and dout are zero.
- R10: A write cycle (wr_n = 0) drives no lane in its own output window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the output pipelines |
| pipe_a_i | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| cs_n_a_i | input | 1 | Port A select, active low |
| cs_a_i | input | 1 | Port A select, active high |
| wr_n_a_i | input | 1 | Port A: 0 write, 1 read |
| lane_n_a_i | input | 2 | Port A lane selects, active low (bit 0 low lane) |
| out_en_n_a_i | input | 1 | Port A asynchronous output enable, active low |
| addr_a_i | input | ADDR_W | Port A word address |
| din_a_i | input | 18 | Port A write data |
| dout_a_o | output | 18 | Port A read data, zero on undriven lanes |
| dout_en_a_o | output | 2 | Port A per-lane drive enable |
| pipe_b_i | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| cs_n_b_i | input | 1 | Port B select, active low |
| cs_b_i | input | 1 | Port B select, active high |
| wr_n_b_i | input | 1 | Port B: 0 write, 1 read |
| lane_n_b_i | input | 2 | Port B lane selects, active low (bit 0 low lane) |
| out_en_n_b_i | input | 1 | Port B asynchronous output enable, active low |
| addr_b_i | input | ADDR_W | Port B word address |
| din_b_i | input | 18 | Port B write data |
| dout_b_o | output | 18 | Port B read data, zero on undriven lanes |
| dout_en_b_o | output | 2 | Port B per-lane drive enable |

## Verification
The assertions check on every cycle of each port's own clock that a high output enable blocks all drive, and that undriven lanes are zero. They also check that any drive traces back to a selected read captured one edge earlier (flow-through) or two edges earlier (pipelined), and that each driven lane was selected at the most recent edge. Only the bench scenarios can show that the stored data is right. These include words written on one port and read on the other, lanes merged by writes from both ports, and writes that are deselected or lane-masked leaving memory untouched. The exact cycle in which data first appears, the one extra cycle of drive after a pipelined deselect, and the output enable acting between clock edges are also shown only by the bench.

// File: rtl/dp_ram_pkg.sv
package dp_ram_pkg;
  localparam int unsigned LANES = 2;
  typedef enum logic {LAT_FLOW = 1'b0, LAT_PIPE = 1'b1} lat_mode_e;
endpackage

// File: rtl/dp_bank.sv
// One write port per bank; the word is recovered as bank_a ^ bank_b.
module dp_bank import dp_ram_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9
) (
  input  logic                      clk_i,
  input  logic [LANES-1:0]          wr_lane_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  input  logic [ADDR_W-1:0]         peer_addr_i,
  output logic [LANES*LANE_W-1:0]   peer_rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned DW    = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_lane_i[l]) mem[addr_i][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
    end
  end

  assign rdata_o      = mem[addr_i];
  assign peer_rdata_o = mem[peer_addr_i];
endmodule

// File: rtl/dp_port.sv
module dp_port import dp_ram_pkg::*; #(
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_i,
  input  logic                    cs_n_i,
  input  logic                    cs_i,
  input  logic                    wr_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  input  logic                    out_en_n_i,
  input  logic [LANES*LANE_W-1:0] word_i,
  output logic [LANES-1:0]        wr_lane_o,
  output logic [LANES*LANE_W-1:0] dout_o,
  output logic [LANES-1:0]        dout_en_o
);
  localparam int unsigned DW = LANES * LANE_W;

  logic             sel_now;
  logic             cs_q1, cs_q2, rd_q1, rd_q2;
  logic [LANES-1:0] lane_q;
  logic [DW-1:0]    data_q1, data_q2;
  logic             cs_eff, rd_eff;
  logic [DW-1:0]    data_eff;
  logic             piped;

  assign sel_now   = ~cs_n_i & cs_i;
  assign wr_lane_o = {LANES{sel_now & ~wr_n_i}} & ~lane_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q1   <= 1'b0;
      cs_q2   <= 1'b0;
      rd_q1   <= 1'b0;
      rd_q2   <= 1'b0;
      lane_q  <= '1;
      data_q1 <= '0;
      data_q2 <= '0;
    end else begin
      cs_q1   <= sel_now;
      cs_q2   <= cs_q1;
      rd_q1   <= wr_n_i;
      rd_q2   <= rd_q1;
      lane_q  <= lane_n_i;   // single stage in both modes
      data_q1 <= word_i;
      data_q2 <= data_q1;
    end
  end

  assign piped    = (lat_mode_e'(pipe_i) == LAT_PIPE);
  assign cs_eff   = piped ? cs_q2   : cs_q1;
  assign rd_eff   = piped ? rd_q2   : rd_q1;
  assign data_eff = piped ? data_q2 : data_q1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dout_en_o[l] = ~out_en_n_i & cs_eff & rd_eff & ~lane_q[l];
    assign dout_o[l*LANE_W +: LANE_W] = dout_en_o[l] ? data_eff[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/dp_bw_ram.sv
module dp_bw_ram import dp_ram_pkg::*; #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk_a_i,
  input  logic                    clk_b_i,
  input  logic                    rst_ni,
  input  logic                    pipe_a_i,
  input  logic                    cs_n_a_i,
  input  logic                    cs_a_i,
  input  logic                    wr_n_a_i,
  input  logic [LANES-1:0]        lane_n_a_i,
  input  logic                    out_en_n_a_i,
  input  logic [ADDR_W-1:0]       addr_a_i,
  input  logic [LANES*LANE_W-1:0] din_a_i,
  output logic [LANES*LANE_W-1:0] dout_a_o,
  output logic [LANES-1:0]        dout_en_a_o,
  input  logic                    pipe_b_i,
  input  logic                    cs_n_b_i,
  input  logic                    cs_b_i,
  input  logic                    wr_n_b_i,
  input  logic [LANES-1:0]        lane_n_b_i,
  input  logic                    out_en_n_b_i,
  input  logic [ADDR_W-1:0]       addr_b_i,
  input  logic [LANES*LANE_W-1:0] din_b_i,
  output logic [LANES*LANE_W-1:0] dout_b_o,
  output logic [LANES-1:0]        dout_en_b_o
);
  localparam int unsigned DW = LANES * LANE_W;

  logic [DW-1:0]    a_own, a_at_b, b_own, b_at_a;
  logic [DW-1:0]    word_a, word_b;
  logic [LANES-1:0] wr_lane_a, wr_lane_b;

  // a_at_b = bank A at port B address, b_at_a = bank B at port A address
  assign word_a = a_own ^ b_at_a;
  assign word_b = b_own ^ a_at_b;

  dp_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank_a (
    .clk_i        (clk_a_i),
    .wr_lane_i    (wr_lane_a),
    .addr_i       (addr_a_i),
    .wdata_i      (din_a_i ^ b_at_a),
    .rdata_o      (a_own),
    .peer_addr_i  (addr_b_i),
    .peer_rdata_o (a_at_b)
  );

  dp_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank_b (
    .clk_i        (clk_b_i),
    .wr_lane_i    (wr_lane_b),
    .addr_i       (addr_b_i),
    .wdata_i      (din_b_i ^ a_at_b),
    .rdata_o      (b_own),
    .peer_addr_i  (addr_a_i),
    .peer_rdata_o (b_at_a)
  );

  dp_port #(.LANE_W(LANE_W)) u_port_a (
    .clk_i      (clk_a_i),
    .rst_ni     (rst_ni),
    .pipe_i     (pipe_a_i),
    .cs_n_i     (cs_n_a_i),
    .cs_i       (cs_a_i),
    .wr_n_i     (wr_n_a_i),
    .lane_n_i   (lane_n_a_i),
    .out_en_n_i (out_en_n_a_i),
    .word_i     (word_a),
    .wr_lane_o  (wr_lane_a),
    .dout_o     (dout_a_o),
    .dout_en_o  (dout_en_a_o)
  );

  dp_port #(.LANE_W(LANE_W)) u_port_b (
    .clk_i      (clk_b_i),
    .rst_ni     (rst_ni),
    .pipe_i     (pipe_b_i),
    .cs_n_i     (cs_n_b_i),
    .cs_i       (cs_b_i),
    .wr_n_i     (wr_n_b_i),
    .lane_n_i   (lane_n_b_i),
    .out_en_n_i (out_en_n_b_i),
    .word_i     (word_b),
    .wr_lane_o  (wr_lane_b),
    .dout_o     (dout_b_o),
    .dout_en_o  (dout_en_b_o)
  );
endmodule

// File: rtl/dp_ram_chk.sv
module dp_ram_chk import dp_ram_pkg::*; #(
  parameter int unsigned LANE_W = 9
) (
  input logic                    clk_a_i,
  input logic                    clk_b_i,
  input logic                    rst_ni,
  input logic                    pipe_a_i,
  input logic                    cs_n_a_i,
  input logic                    cs_a_i,
  input logic                    wr_n_a_i,
  input logic [LANES-1:0]        lane_n_a_i,
  input logic                    out_en_n_a_i,
  input logic [LANES*LANE_W-1:0] dout_a_o,
  input logic [LANES-1:0]        dout_en_a_o,
  input logic                    pipe_b_i,
  input logic                    cs_n_b_i,
  input logic                    cs_b_i,
  input logic                    wr_n_b_i,
  input logic [LANES-1:0]        lane_n_b_i,
  input logic                    out_en_n_b_i,
  input logic [LANES*LANE_W-1:0] dout_b_o,
  input logic [LANES-1:0]        dout_en_b_o
);
  logic [LANES*LANE_W-1:0] off_a, off_b;
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      off_a[l*LANE_W +: LANE_W] = {LANE_W{~dout_en_a_o[l]}};
      off_b[l*LANE_W +: LANE_W] = {LANE_W{~dout_en_b_o[l]}};
    end
  end

  // R8
  oe_gate_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    out_en_n_a_i |-> dout_en_a_o == '0);
  // R8
  oe_gate_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    out_en_n_b_i |-> dout_en_b_o == '0);
  // R5
  idle_lane_zero_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (dout_a_o & off_a) == '0);
  // R5
  idle_lane_zero_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (dout_b_o & off_b) == '0);
  // R6
  flow_src_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!pipe_a_i && dout_en_a_o != '0) |-> $past(!cs_n_a_i && cs_a_i && wr_n_a_i));
  // R6
  flow_src_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!pipe_b_i && dout_en_b_o != '0) |-> $past(!cs_n_b_i && cs_b_i && wr_n_b_i));
  // R7
  pipe_src_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (pipe_a_i && dout_en_a_o != '0) |-> $past(!cs_n_a_i && cs_a_i && wr_n_a_i, 2));
  // R7
  pipe_src_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (pipe_b_i && dout_en_b_o != '0) |-> $past(!cs_n_b_i && cs_b_i && wr_n_b_i, 2));
  // R7
  lane_src_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (dout_en_a_o & $past(lane_n_a_i)) == '0);
  // R7
  lane_src_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (dout_en_b_o & $past(lane_n_b_i)) == '0);

  // R9
  always @(posedge clk_a_i) begin
    if (rst_ni === 1'b0) reset_quiet_chk: assert (dout_en_a_o == '0 && dout_en_b_o == '0);
  end
endmodule

bind dp_bw_ram dp_ram_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_dp_bw_ram.sv
module tb_dp_bw_ram;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = 14;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk_a = 0, clk_b = 0, rst_ni = 0;
  logic pipe_a = 0, cs_n_a = 1, cs_a = 1, wr_n_a = 1, oe_n_a = 0;
  logic pipe_b = 0, cs_n_b = 1, cs_b = 1, wr_n_b = 1, oe_n_b = 0;
  logic [1:0] ln_a = 2'b11, ln_b = 2'b11;
  logic [ADDR_W-1:0] addr_a = '0, addr_b = '0;
  logic [17:0] din_a = '0, din_b = '0;
  logic [17:0] dout_a, dout_b;
  logic [1:0]  den_a, den_b;

  logic [17:0] model [DEPTH];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;

  dp_bw_ram #(.ADDR_W(ADDR_W), .LANE_W(9)) dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_ni),
    .pipe_a_i(pipe_a), .cs_n_a_i(cs_n_a), .cs_a_i(cs_a), .wr_n_a_i(wr_n_a),
    .lane_n_a_i(ln_a), .out_en_n_a_i(oe_n_a), .addr_a_i(addr_a), .din_a_i(din_a),
    .dout_a_o(dout_a), .dout_en_a_o(den_a),
    .pipe_b_i(pipe_b), .cs_n_b_i(cs_n_b), .cs_b_i(cs_b), .wr_n_b_i(wr_n_b),
    .lane_n_b_i(ln_b), .out_en_n_b_i(oe_n_b), .addr_b_i(addr_b), .din_b_i(din_b),
    .dout_b_o(dout_b), .dout_en_b_o(den_b)
  );

  function automatic logic [17:0] pat(int a, int salt);
    return 18'((a * 1021 + 77 + salt) ^ (a << 7));
  endfunction

  function automatic logic [17:0] masked(logic [17:0] w, logic [1:0] ln);
    return {ln[1] ? 9'd0 : w[17:9], ln[0] ? 9'd0 : w[8:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic upd(input logic cn, input logic c, input logic w, input logic [1:0] ln,
                     input int a, input logic [17:0] d);
    if (!cn && c && !w) begin
      if (!ln[0]) model[a][8:0]  = d[8:0];
      if (!ln[1]) model[a][17:9] = d[17:9];
    end
  endtask

  task automatic op_a(input logic cn, input logic c, input logic w, input logic [1:0] ln,
                      input int a, input logic [17:0] d);
    cs_n_a = cn; cs_a = c; wr_n_a = w; ln_a = ln; addr_a = ADDR_W'(a); din_a = d;
    @(posedge clk_a); #1;
    upd(cn, c, w, ln, a, d);
  endtask

  task automatic op_b(input logic cn, input logic c, input logic w, input logic [1:0] ln,
                      input int a, input logic [17:0] d);
    cs_n_b = cn; cs_b = c; wr_n_b = w; ln_b = ln; addr_b = ADDR_W'(a); din_b = d;
    @(posedge clk_b); #1;
    upd(cn, c, w, ln, a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9 reset quiet
    repeat (3) @(posedge clk_a);
    #1;
    chk("R9 en_a", 32'(den_a), 0);
    chk("R9 dout_a", 32'(dout_a), 0);
    chk("R9 en_b", 32'(den_b), 0);
    chk("R9 dout_b", 32'(dout_b), 0);
    #3 rst_ni = 1;
    op_a(1, 1, 1, 2'b11, 0, 0);

    // R1: fill from A, read all from B (flow)
    for (int a = 0; a < DEPTH; a++) begin
      op_a(0, 1, 0, 2'b00, a, pat(a, 0));
      chk("R10 en_a after write", 32'(den_a), 0);
    end
    op_a(1, 1, 1, 2'b11, 0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      op_b(0, 1, 1, 2'b00, a, 0);
      chk("R1 R6 flow read b", 32'(dout_b), 32'(model[a]));
      chk("R6 flow en b", 32'(den_b), 2'b11);
    end

    // R2: lane-only writes from B, read on A
    for (int a = 0; a < DEPTH; a++)
      op_b(0, 1, 0, (a % 2 == 0) ? 2'b01 : 2'b10, a, pat(a, 5000));
    op_b(1, 1, 1, 2'b11, 0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      op_a(0, 1, 1, 2'b00, a, 0);
      chk("R2 lane merge", 32'(dout_a), 32'(model[a]));
    end

    // R3 / R4: blocked writes
    op_a(1, 1, 0, 2'b00, 3, 18'h3ffff);
    chk("R3 cs_n high no drive", 32'(den_a), 0);
    op_a(0, 0, 0, 2'b00, 4, 18'h3ffff);
    chk("R3 cs low no drive", 32'(den_a), 0);
    op_a(0, 1, 0, 2'b11, 5, 18'h3ffff);
    op_a(0, 1, 1, 2'b11, 5, 0);
    chk("R4 no lanes no drive", 32'(den_a), 0);
    op_b(0, 1, 0, 2'b11, 6, 18'h3ffff);
    for (int a = 3; a <= 6; a++) begin
      op_a(0, 1, 1, 2'b00, a, 0);
      chk("R3 R4 memory untouched", 32'(dout_a), 32'(model[a]));
    end

    // R5 partial reads
    op_a(0, 1, 1, 2'b01, 9, 0);
    chk("R5 upper only en", 32'(den_a), 2'b10);
    chk("R5 upper only data", 32'(dout_a), 32'(masked(model[9], 2'b01)));
    op_b(0, 1, 1, 2'b10, 10, 0);
    chk("R5 lower only en", 32'(den_b), 2'b01);
    chk("R5 lower only data", 32'(dout_b), 32'(masked(model[10], 2'b10)));

    // R8 async output enable
    op_a(0, 1, 1, 2'b00, 11, 0);
    oe_n_a = 1; #1;
    chk("R8 oe off en", 32'(den_a), 0);
    chk("R8 oe off data", 32'(dout_a), 0);
    oe_n_a = 0; #1;
    chk("R8 oe back", 32'(dout_a), 32'(model[11]));

    // flow deselect is immediate
    op_a(1, 1, 1, 2'b00, 0, 0);
    chk("R7 flow deselect", 32'(den_a), 0);

    // pipelined port B
    op_b(1, 1, 1, 2'b11, 0, 0);
    op_b(1, 1, 1, 2'b11, 0, 0);
    pipe_b = 1;
    op_b(1, 1, 1, 2'b11, 0, 0);
    op_b(1, 1, 1, 2'b11, 0, 0);
    for (int a = 0; a < DEPTH; a++) begin
      op_b(0, 1, 1, 2'b00, a, 0);
      if (a == 0) chk("R6 pipe no early data", 32'(den_b), 0);
      else chk("R6 pipe read", 32'(dout_b), 32'(model[a-1]));
    end
    // deselected but still driving one cycle
    op_b(1, 1, 1, 2'b00, 0, 0);
    chk("R7 pipe deselect lag en", 32'(den_b), 2'b11);
    chk("R7 pipe deselect lag data", 32'(dout_b), 32'(model[DEPTH-1]));
    op_b(1, 1, 1, 2'b00, 0, 0);
    chk("R7 pipe deselect done", 32'(den_b), 0);
    // lane select single stage
    op_b(0, 1, 1, 2'b00, 20, 0);
    op_b(0, 1, 1, 2'b01, 21, 0);
    chk("R7 lane from latest edge en", 32'(den_b), 2'b10);
    chk("R7 lane from latest edge data", 32'(dout_b), 32'(masked(model[20], 2'b01)));
    // write window in pipe mode
    op_b(0, 1, 0, 2'b00, 30, pat(30, 9));
    chk("R7 prior read still out", 32'(dout_b), 32'(model[21]));
    op_b(1, 1, 1, 2'b00, 0, 0);
    chk("R10 pipe write no drive", 32'(den_b), 0);
    op_a(0, 1, 1, 2'b00, 30, 0);
    chk("R1 b write seen on a", 32'(dout_a), 32'(model[30]));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule